// File: doc/BRIEF.md
# Lockstep LFSR Disagreement Checker

This block is a self-test checker for replicated logic. It holds a number of identical, identically seeded maximal-length LFSR cells that step together while `go` is high. The cells are split into groups, and each group feeds one stage of a comparator chain. Every stage holds a one-bit token that is 1 when all is well. A stage loads 0 when the top bits of its own cells differ, or when the stage before it already holds 0. A zero therefore moves one stage toward the end of the chain on each clock. A sticky catcher at the tail raises `err_flag` and keeps it set until a clear or a reset. There is no central comparator.

A forced-error input drives only the upstream side of the first stage. It lets the whole detection path be exercised without corrupting any cell. An upset input flips the top bit of a chosen cell's next state, so that real disagreements can be produced. The top bit of cell 0 is fed one bit per stepping cycle into a serial CRC. That CRC is exported as a signature, which can be compared against a value computed offline.

Top module: `lockstep_err_chain`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `err_flag` is 0 and `signature` equals the CRC initial value 16'hFFFF.
- R2: Each cell is an 8-bit Fibonacci LFSR seeded to 8'h01. On each clock with `go` high it shifts left, and the new bit 0 is the XOR of state bits 7, 5, 4 and 3. With `go` low and no upset, it holds its state.
- R3: On each clock with `go` high, the signature takes the top bit of cell 0 before that cell steps (d) and updates as a CRC with polynomial 16'h1021: fb = sig[15]^d, sig = (sig<<1) ^ (fb ? 16'h1021 : 0). With `go` low it holds.
- R4: Bit s*3+c of `upset_inj` flips bit 7 of the next state of cell c in stage s (4 stages, 3 cells each). If it is sampled at clock edge 1, `err_flag` first reads 1 after edge 6-s.
- R5: A disagreement is still detected and carried down the chain when `go` is low.
- R6: `force_err` sampled high at edge 1 enters only the first stage, and `err_flag` first reads 1 after edge 5.
- R7: Once set, `err_flag` stays at 1 until `clr` or `rst`, even after the chain has gone back to all ones.
- R8: A synchronous `clr` clears `err_flag`, sets `signature` to 16'hFFFF and reseeds every cell. No error appears afterwards without new stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Steps the LFSR cells and the signature CRC |
| clr | input | 1 | Synchronous clear of cells, tokens, catcher and signature |
| force_err | input | 1 | Inserts an error token upstream of the first stage |
| upset_inj | input | 12 | Per-cell flip of the next-state top bit |
| err_flag | output | 1 | Sticky error indication from the chain tail |
| signature | output | 16 | Serial CRC of cell 0's top bit |

## Verification
The assertions assume that `clr` and `rst` are the only ways the tokens and the catcher return to their idle values, and that `force_err` and `upset_inj` are driven as clean, synchronous pulses. The stimulus changes every input on the falling edge only. Each latency case starts from a clear, so that no earlier disagreement is still present in the cells. Upsets are single-cycle pulses into one cell at a time. The window in which `go` is paused starts from a known count of stepping cycles, so the expected signature can be predicted.

// File: rtl/lsec_pkg.sv
package lsec_pkg;

    typedef enum logic {
        TOK_ERR = 1'b0,
        TOK_OK  = 1'b1
    } token_e;

    typedef struct packed {
        logic go;
        logic clr;
    } ctl_t;

    // Maximal-length Fibonacci tap masks; bit k set means state bit k feeds back.
    function automatic logic [31:0] lfsr_taps(input int unsigned width);
        case (width)
            3:       return 32'h0000_0006;
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            11:      return 32'h0000_0500;
            12:      return 32'h0000_0829;
            13:      return 32'h0000_100D;
            14:      return 32'h0000_2015;
            15:      return 32'h0000_6000;
            16:      return 32'h0000_D008;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/lsec_lfsr_cell.sv
module lsec_lfsr_cell
    import lsec_pkg::*;
#(
    parameter int          W    = 8,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  logic upset,
    output logic msb
);
    localparam logic [W-1:0] TAPS     = W'(lfsr_taps(W));
    localparam logic [W-1:0] TOP_FLIP = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] state;
    logic [W-1:0] state_nx;

    always_comb begin
        state_nx = state;
        if (ctl.go)
            state_nx = {state[W-2:0], ^(state & TAPS)};
        if (upset)
            state_nx = state_nx ^ TOP_FLIP;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr)
            state <= SEED;
        else
            state <= state_nx;
    end

    assign msb = state[W-1];

    // R2
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.go && !upset && !ctl.clr) |=> $stable(state));

endmodule

// File: rtl/lsec_cmp_stage.sv
module lsec_cmp_stage
    import lsec_pkg::*;
#(
    parameter int K = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [K-1:0] cell_msb,
    input  token_e       tok_in,
    output token_e       tok_out
);
    logic agree;

    assign agree = (&cell_msb) | ~(|cell_msb);

    always_ff @(posedge clk) begin
        if (rst || clr)
            tok_out <= TOK_OK;
        else if (agree && tok_in == TOK_OK)
            tok_out <= TOK_OK;
        else
            tok_out <= TOK_ERR;
    end

endmodule

// File: rtl/lsec_catcher.sv
module lsec_catcher
    import lsec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  token_e tail,
    output logic   err
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            err <= 1'b0;
        else if (tail == TOK_ERR)
            err <= 1'b1;
    end

    // R7
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !clr) |=> err);

endmodule

// File: rtl/lsec_sig_crc.sv
module lsec_sig_crc
    import lsec_pkg::*;
#(
    parameter int               CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h1021,
    parameter logic [CRC_W-1:0] INIT  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic fb;

    assign fb = crc[CRC_W-1] ^ din;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr)
            crc <= INIT;
        else if (ctl.go)
            crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // R3
    sig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.go && !ctl.clr) |=> $stable(crc));

endmodule

// File: rtl/lockstep_err_chain.sv
module lockstep_err_chain
    import lsec_pkg::*;
#(
    parameter int               N_STAGES = 4,
    parameter int               K        = 3,
    parameter int               W        = 8,
    parameter logic [W-1:0]     SEED     = 8'h01,
    parameter int               CRC_W    = 16,
    parameter logic [CRC_W-1:0] POLY     = 16'h1021,
    parameter logic [CRC_W-1:0] INIT     = '1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic                  clr,
    input  logic                  force_err,
    input  logic [N_STAGES*K-1:0] upset_inj,
    output logic                  err_flag,
    output logic [CRC_W-1:0]      signature
);
    localparam int N_CELLS = N_STAGES * K;

    ctl_t               ctl;
    logic [N_CELLS-1:0] cell_msb;
    token_e             tok [N_STAGES];
    token_e             head;

    assign ctl.go  = go;
    assign ctl.clr = clr;
    assign head    = force_err ? TOK_ERR : TOK_OK;

    for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
        lsec_lfsr_cell #(.W(W), .SEED(SEED)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .upset (upset_inj[c]),
            .msb   (cell_msb[c])
        );
    end

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            lsec_cmp_stage #(.K(K)) u_stage (
                .clk      (clk),
                .rst      (rst),
                .clr      (clr),
                .cell_msb (cell_msb[K-1:0]),
                .tok_in   (head),
                .tok_out  (tok[0])
            );
        end else begin : g_rest
            lsec_cmp_stage #(.K(K)) u_stage (
                .clk      (clk),
                .rst      (rst),
                .clr      (clr),
                .cell_msb (cell_msb[s*K +: K]),
                .tok_in   (tok[s-1]),
                .tok_out  (tok[s])
            );

            // R4
            chain_prop_chk: assert property (@(posedge clk) disable iff (rst)
                (tok[s-1] == TOK_ERR && !clr) |=> tok[s] == TOK_ERR);
        end
    end

    lsec_catcher u_catch (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .tail (tok[N_STAGES-1]),
        .err  (err_flag)
    );

    lsec_sig_crc #(.CRC_W(CRC_W), .POLY(POLY), .INIT(INIT)) u_sig (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .din (cell_msb[0]),
        .crc (signature)
    );

    // R6
    force_first_chk: assert property (@(posedge clk) disable iff (rst)
        (force_err && !clr) |=> tok[0] == TOK_ERR);

    // R8
    clear_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (!err_flag && signature == INIT));

    // R7
    err_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(tok[N_STAGES-1]) == TOK_ERR);

endmodule

// File: tb/lockstep_err_chain_tb.sv
module lockstep_err_chain_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic        clr = 1'b0;
    logic        force_err = 1'b0;
    logic [11:0] upset_inj = '0;
    logic        err_flag;
    logic [15:0] signature;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    lockstep_err_chain u_dut (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .clr       (clr),
        .force_err (force_err),
        .upset_inj (upset_inj),
        .err_flag  (err_flag),
        .signature (signature)
    );

    // Vector table: cell index to upset (-1 means force_err), go level, expected edge of err.
    localparam int NV = 7;
    localparam int V_IDX [NV] = '{-1, 0, 4, 7, 11, 9, 5};
    localparam int V_GO  [NV] = '{ 1, 1, 1, 1,  1, 1, 0};
    localparam int V_LAT [NV] = '{ 5, 6, 5, 4,  3, 3, 5};

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_sig(input int steps);
        logic [7:0]  st  = 8'h01;
        logic [15:0] crc = 16'hFFFF;
        for (int i = 0; i < steps; i++) begin
            logic d;
            logic fb;
            d   = st[7];
            fb  = crc[15] ^ d;
            crc = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            st  = {st[6:0], st[7] ^ st[5] ^ st[4] ^ st[3]};
        end
        return crc;
    endfunction

    task automatic do_clear();
        clr = 1'b1;
        tick();
        clr = 1'b0;
    endtask

    task automatic measure(input int idx, output int lat);
        if (idx < 0) force_err = 1'b1;
        else         upset_inj[idx] = 1'b1;
        tick();
        force_err = 1'b0;
        upset_inj = '0;
        lat = 1;
        while (!err_flag && lat < 20) begin
            tick();
            lat++;
        end
    endtask

    initial begin
        int lat;
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;
        // R1: state straight after reset
        check(err_flag == 1'b0, "R1 err after reset", err_flag, 0);
        check(signature == 16'hFFFF, "R1 signature after reset", signature, 16'hFFFF);

        // R4, R5, R6: table of injections and expected latencies
        for (int v = 0; v < NV; v++) begin
            do_clear();
            go = V_GO[v][0];
            repeat (3) tick();
            check(err_flag == 1'b0, "R8 no error before injection", err_flag, 0);
            measure(V_IDX[v], lat);
            if (V_IDX[v] < 0)
                check(lat == V_LAT[v], "R6 force latency", lat, V_LAT[v]);
            else if (V_GO[v] == 0)
                check(lat == V_LAT[v], "R5 upset latency with go low", lat, V_LAT[v]);
            else
                check(lat == V_LAT[v], "R4 upset latency", lat, V_LAT[v]);
        end

        // R7: a single force pulse leaves the flag set after the chain recovers
        do_clear();
        go = 1'b1;
        measure(-1, lat);
        repeat (10) tick();
        check(err_flag == 1'b1, "R7 sticky error", err_flag, 1);

        // R8: clear empties the catcher and resets the signature
        do_clear();
        check(err_flag == 1'b0, "R8 err after clear", err_flag, 0);
        check(signature == 16'hFFFF, "R8 signature after clear", signature, 16'hFFFF);
        go = 1'b0;
        do_clear();

        // R2, R3: signature across stepping, paused and resumed windows
        go = 1'b1;
        repeat (20) tick();
        check(signature == model_sig(20), "R3 signature after 20 steps", signature, model_sig(20));
        go = 1'b0;
        repeat (5) tick();
        check(signature == model_sig(20), "R2 R3 hold while go low", signature, model_sig(20));
        go = 1'b1;
        repeat (12) tick();
        check(signature == model_sig(32), "R2 R3 signature after resume", signature, model_sig(32));
        check(err_flag == 1'b0, "R8 no error after reseed", err_flag, 0);

        // R6: a held force keeps the flag set
        force_err = 1'b1;
        repeat (8) tick();
        force_err = 1'b0;
        check(err_flag == 1'b1, "R6 held force", err_flag, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule